// File: doc/BRIEF.md
# Buck Regulator Startup Sequencer

This block takes a synchronous buck regulator from reset to regulation. It waits until the supply has cleared power-on reset and the enable input is high. It then sends short, low-duty probe pulses on the high-side gate request. A comparator watches the switch node during these pulses, and the block counts its transitions. When enough transitions have been seen, the input rail is taken as present.

Next, the block holds the low-side gate request for a fixed number of clock cycles to drain any charge already on the output. It then raises a digital soft-start reference code one step at a time, from zero to full scale. When the code reaches full scale, it raises a done flag.

If the enable input or the supply-ok flag goes low, everything drops back to its reset state. A restart pulse from the fault supervisor starts the ramp again from zero without probing again. All timing intervals are parameters counted in clock cycles.

Top module: `buck_start_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `hs_req`, `ls_req` and `ss_done` are 0 after that edge, and `ss_code` is 0.
- R2: While `por_ok` and `en` are not both high, no probe pulse is sent: `hs_req` stays 0.
- R3: While probing, `hs_req` is high for exactly PROBE_HIGH consecutive cycles out of every PROBE_PERIOD cycles.
- R4: The rail is declared ready on the EDGES_NEEDED-th transition (default 4) of the synchronized `probe_cmp`. Rising and falling transitions each count as one. With fewer transitions the block keeps probing indefinitely: `ls_req` stays 0 and `ss_code` stays 0.
- R5: `probe_cmp` transitions that occur before probing begins are not counted toward readiness.
- R6: Once the rail is ready, `ls_req` is high for exactly DISCHG_CYC consecutive cycles. During that time `hs_req` is 0 and `ss_code` is 0.
- R7: After the discharge, `ss_code` rises by exactly 1 every STEP_CYC cycles, never decreases, and holds at all-ones.
- R8: `ss_done` is 1 only while `ss_code` is all-ones during the ramp. It rises at most one cycle after the code reaches all-ones.
- R9: If `en` or `por_ok` is low at a clock edge, then after that edge `hs_req`, `ls_req`, `ss_done` and `ss_code` are all 0. When the block is enabled again, it starts probing again and needs a fresh set of transitions.
- R10: A `restart` pulse during the discharge or the ramp clears `ss_code` and `ss_done` at the next edge. The ramp then repeats from zero with no probe pulse and no discharge.
- R11: A `restart` pulse while the block is idle or probing has no effect: probing continues, and `ls_req` and `ss_code` stay 0.
- R12: `hs_req` and `ls_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Supply has passed its power-on-reset threshold |
| en | input | 1 | Enable; low means shutdown |
| probe_cmp | input | 1 | Asynchronous probe comparator output |
| restart | input | 1 | Restart-ramp request from the fault supervisor |
| hs_req | output | 1 | High-side gate request (probe pulses) |
| ls_req | output | 1 | Low-side gate request (pre-bias discharge) |
| ss_code | output | CODE_W | Soft-start reference code |
| ss_done | output | 1 | Soft-start code has reached full scale |

## Verification
The bench goes after the edge-count boundary first. It gives three transitions and then waits several probe periods; a design that counted only rising edges, or was off by one, would either start too early or never start. It toggles the comparator before probing begins, to catch a counter that does not clear when the block is idle. It also measures the exact discharge width and the exact spacing between ramp steps, where an off-by-one timer shows up as a wrong count. Finally, it applies restart both while probing and while ramping, and shutdown both during discharge and during the ramp. A design with the wrong priority would re-probe, skip the ramp reset, or leave a gate request asserted.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PROBE  = 2'd1,
    ST_DISCHG = 2'd2,
    ST_RAMP   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/bss_sync.sv
// Multi-flop synchronizer with a one-cycle pulse on every change of the
// synchronized level (both directions).
module bss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_p
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign edge_p = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/bss_probe_gen.sv
// Free-running probe pulse timer: high for HIGH cycles of every PERIOD.
module bss_probe_gen #(
  parameter int PERIOD = 25000,
  parameter int HIGH   = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic pulse_hi
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW:0]   HI_W = (CW+1)'(HIGH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_hi = run && ({1'b0, cnt_q} < HI_W);
endmodule

// File: rtl/bss_ramp.sv
// Soft-start code counter with a step prescaler.
module bss_ramp #(
  parameter int CODE_W = 10,
  parameter int STEP   = 855
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  output logic [CODE_W-1:0] code,
  output logic              full
);
  localparam int PW = (STEP > 1) ? $clog2(STEP) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(STEP - 1);

  logic [PW-1:0]     pre_q;
  logic [CODE_W-1:0] code_q;

  assign full = &code_q;
  assign code = code_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q  <= '0;
      code_q <= '0;
    end else if (run && !full) begin
      if (pre_q == PRE_LAST) begin
        pre_q  <= '0;
        code_q <= code_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/buck_start_seq.sv
module buck_start_seq
  import buck_seq_pkg::*;
#(
  parameter int PROBE_PERIOD = 25000,
  parameter int PROBE_HIGH   = 250,
  parameter int EDGES_NEEDED = 4,
  parameter int DISCHG_CYC   = 2500,
  parameter int CODE_W       = 10,
  parameter int STEP_CYC     = 855,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_ok,
  input  logic              en,
  input  logic              probe_cmp,
  input  logic              restart,
  output logic              hs_req,
  output logic              ls_req,
  output logic [CODE_W-1:0] ss_code,
  output logic              ss_done
);
  localparam int ECW = $clog2(EDGES_NEEDED + 1);
  localparam logic [ECW-1:0] EDGE_LAST = ECW'(EDGES_NEEDED - 1);
  localparam int DCW = (DISCHG_CYC > 1) ? $clog2(DISCHG_CYC) : 1;
  localparam logic [DCW-1:0] DIS_LAST = DCW'(DISCHG_CYC - 1);

  seq_state_t state_q, state_d;
  logic live, restart_take, cmp_edge, probe_hi, ramp_full;
  logic [ECW-1:0] edge_cnt_q;
  logic [DCW-1:0] dis_cnt_q;
  logic hs_q, ls_q, done_q;

  assign live         = por_ok && en;
  assign restart_take = live && restart &&
                        (state_q == ST_DISCHG || state_q == ST_RAMP);

  bss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(probe_cmp), .edge_p(cmp_edge)
  );

  bss_probe_gen #(.PERIOD(PROBE_PERIOD), .HIGH(PROBE_HIGH)) u_probe (
    .clk(clk), .rst(rst), .run(live && state_q == ST_PROBE),
    .pulse_hi(probe_hi)
  );

  bss_ramp #(.CODE_W(CODE_W), .STEP(STEP_CYC)) u_ramp (
    .clk(clk), .rst(rst),
    .clr(!live || restart_take || state_q != ST_RAMP),
    .run(state_q == ST_RAMP),
    .code(ss_code), .full(ramp_full)
  );

  always_comb begin
    state_d = state_q;
    if (!live)             state_d = ST_IDLE;
    else if (restart_take) state_d = ST_RAMP;
    else begin
      unique case (state_q)
        ST_IDLE:   state_d = ST_PROBE;
        ST_PROBE:  if (cmp_edge && edge_cnt_q == EDGE_LAST) state_d = ST_DISCHG;
        ST_DISCHG: if (dis_cnt_q == DIS_LAST) state_d = ST_RAMP;
        ST_RAMP:   state_d = ST_RAMP;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      edge_cnt_q <= '0;
      dis_cnt_q  <= '0;
      hs_q       <= 1'b0;
      ls_q       <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!live || state_q != ST_PROBE) edge_cnt_q <= '0;
      else if (cmp_edge)                edge_cnt_q <= edge_cnt_q + 1'b1;
      if (!live || state_q != ST_DISCHG) dis_cnt_q <= '0;
      else                               dis_cnt_q <= dis_cnt_q + 1'b1;
      hs_q   <= probe_hi;
      ls_q   <= live && !restart_take && state_q == ST_DISCHG;
      done_q <= live && !restart_take && state_q == ST_RAMP && ramp_full;
    end
  end

  assign hs_req  = hs_q;
  assign ls_req  = ls_q;
  assign ss_done = done_q;
endmodule

// File: rtl/bss_checker.sv
module bss_checker #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              por_ok,
  input logic              en,
  input logic              hs_req,
  input logic              ls_req,
  input logic [CODE_W-1:0] ss_code,
  input logic              ss_done
);
  p_gates_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(hs_req && ls_req));

  p_off_when_down_r9: assert property (@(posedge clk) disable iff (rst)
    !(por_ok && en) |=> (!hs_req && !ls_req && !ss_done && ss_code == '0));

  p_code_step_r7: assert property (@(posedge clk) disable iff (rst)
    (ss_code != $past(ss_code) && ss_code != '0) |-> ss_code == $past(ss_code) + 1'b1);

  p_done_full_r8: assert property (@(posedge clk) disable iff (rst)
    ss_done |-> (&ss_code));

  p_dischg_zero_r6: assert property (@(posedge clk) disable iff (rst)
    ls_req |-> (ss_code == '0 && !ss_done));
endmodule

bind buck_start_seq bss_checker #(.CODE_W(CODE_W)) u_bss_checker (
  .clk(clk), .rst(rst), .por_ok(por_ok), .en(en),
  .hs_req(hs_req), .ls_req(ls_req), .ss_code(ss_code), .ss_done(ss_done)
);

// File: tb/test_buck_start_seq.sv
module test_buck_start_seq;
  localparam int PER = 20, HI = 2, EDG = 4, DIS = 8, CW = 4, STP = 3;
  localparam logic [CW-1:0] FULL = '1;

  logic clk = 1'b0, rst = 1'b1, por_ok = 1'b0, en = 1'b0, cmp = 1'b0, restart = 1'b0;
  logic hs, ls, done;
  logic [CW-1:0] code;
  int total = 0, bad = 0, excl_viol = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  buck_start_seq #(
    .PROBE_PERIOD(PER), .PROBE_HIGH(HI), .EDGES_NEEDED(EDG),
    .DISCHG_CYC(DIS), .CODE_W(CW), .STEP_CYC(STP), .SYNC_STAGES(2)
  ) i_buck_start_seq (
    .clk(clk), .rst(rst), .por_ok(por_ok), .en(en), .probe_cmp(cmp),
    .restart(restart), .hs_req(hs), .ls_req(ls), .ss_code(code), .ss_done(done)
  );

  always @(negedge clk) if (!rst && hs && ls) excl_viol++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts hs/ls high cycles and nonzero code over a window.
  task automatic window(input int n, output int hs_n, output int ls_n,
                        output int code_nz, output int max_run);
    int run_len;
    hs_n = 0; ls_n = 0; code_nz = 0; max_run = 0; run_len = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (hs) begin hs_n++; run_len++; if (run_len > max_run) max_run = run_len; end
      else run_len = 0;
      if (ls) ls_n++;
      if (code != '0) code_nz++;
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; por_ok = 1'b0; en = 1'b0;
    cyc(3);
    check(!hs && !ls && !done && code == '0, "R1", "outputs in reset",
          {hs, ls, done}, 0);
    rst = 1'b0;
    cyc(2);
    check(!hs && !ls && code == '0, "R1", "outputs after reset", {hs, ls}, 0);
  endtask

  task automatic t_hold_off;
    int hs_seen = 0, h, l, c, m;
    en = 1'b1; por_ok = 1'b0;
    for (int k = 0; k < 6; k++) begin
      cmp = ~cmp;
      for (int j = 0; j < 5; j++) begin cyc(1); if (hs || ls) hs_seen++; end
    end
    check(hs_seen == 0, "R2", "no probe while supply not ok", hs_seen, 0);
    por_ok = 1'b1;
    cyc(2);
    window(2 * PER, h, l, c, m);
    check(h == 2 * HI, "R3", "probe high cycles in two periods", h, 2 * HI);
    check(m == HI, "R3", "probe pulse width", m, HI);
    check(l == 0 && c == 0, "R5", "early transitions not counted", l + c, 0);
  endtask

  task automatic wait_discharge(input string req);
    int t = 0, w = 0;
    bit side_ok = 1'b1;
    while (!ls && t < 20) begin cyc(1); t++; end
    check(ls, req, "discharge started after qualifying edges", ls, 1);
    while (ls && w < 100) begin
      if (hs || code != '0) side_ok = 1'b0;
      w++; cyc(1);
    end
    check(w == DIS, "R6", "discharge width", w, DIS);
    check(side_ok, "R6", "hs low and code zero during discharge", side_ok, 1);
  endtask

  task automatic t_qualify;
    int h, l, c, m;
    for (int k = 0; k < EDG - 1; k++) begin cmp = ~cmp; cyc(4); end
    window(3 * PER, h, l, c, m);
    check(l == 0 && c == 0, "R4", "three transitions do not qualify", l + c, 0);
    check(h == 3 * HI, "R4", "still probing after three transitions", h, 3 * HI);
    cmp = ~cmp;
    wait_discharge("R4");
  endtask

  task automatic watch_ramp(input string tag);
    logic [CW-1:0] prev;
    int last = -1, changes = 0, gates = 0, i = 0;
    bit inc_ok = 1'b1, step_ok = 1'b1, early = 1'b0;
    prev = code;
    while (!done && i < (1 << CW) * STP + 20) begin
      cyc(1); i++;
      if (hs || ls) gates++;
      if (code != prev) begin
        if (code != prev + 1'b1) inc_ok = 1'b0;
        if (last >= 0 && (i - last) != STP) step_ok = 1'b0;
        last = i; changes++; prev = code;
      end
      if (done && code != FULL) early = 1'b1;
    end
    check(changes == (1 << CW) - 1, "R7", {tag, " step count"}, changes, (1 << CW) - 1);
    check(inc_ok, "R7", {tag, " steps of one"}, inc_ok, 1);
    check(step_ok, "R7", {tag, " step spacing"}, step_ok, 1);
    check(done && code == FULL && !early, "R8", {tag, " done at full scale"}, code, FULL);
    check(gates == 0, tag, "no gate request during ramp", gates, 0);
    cyc(10);
    check(code == FULL && done, "R7", {tag, " code holds at full"}, code, FULL);
  endtask

  task automatic t_restart;
    restart = 1'b1; cyc(1); restart = 1'b0;
    check(code == '0 && !done, "R10", "restart after done clears code", code, 0);
    watch_ramp("R10");
    cyc(STP * 5);
    restart = 1'b1; cyc(1); restart = 1'b0;
    check(code == '0 && !done, "R10", "restart mid ramp clears code", code, 0);
    watch_ramp("R10");
  endtask

  task automatic t_shutdown;
    int h, l, c, m;
    restart = 1'b1; cyc(1); restart = 1'b0;
    cyc(STP * 4);
    en = 1'b0; cyc(1);
    check(!hs && !ls && !done && code == '0, "R9", "en low forces off", code, 0);
    cyc(5);
    en = 1'b1; cyc(2);
    window(2 * PER, h, l, c, m);
    check(h == 2 * HI && l == 0 && c == 0, "R9", "re-enable probes again", h, 2 * HI);
    restart = 1'b1; cyc(1); restart = 1'b0;
    window(2 * PER, h, l, c, m);
    check(l == 0 && c == 0, "R11", "restart while probing ignored", l + c, 0);
    check(h == 2 * HI, "R11", "probing continues after restart", h, 2 * HI);
    for (int k = 0; k < EDG; k++) begin cmp = ~cmp; cyc(4); end
    while (!ls) cyc(1);
    por_ok = 1'b0; cyc(1);
    check(!hs && !ls && code == '0, "R9", "supply loss forces off", ls, 0);
  endtask

  initial begin
    t_reset();
    t_hold_off();
    t_qualify();
    watch_ramp("R7");
    t_restart();
    t_shutdown();
    check(excl_viol == 0, "R12", "gate requests never both high", excl_viol, 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule